// File: doc/BRIEF.md
# EEPROM Image Checksum Writer

This block rebuilds the checksum word of a 64-word, 16-bit EEPROM image. After a start pulse, it reads the first 63 words one at a time through a generic word-read port and keeps a running 16-bit sum. It then subtracts that sum from the signature constant 0xBABA and writes the result to the last word, so that the whole image sums to the signature.

Both ports use a request/ready handshake. The block holds a request and its address stable until the port raises ready. The error input is sampled in the same cycle as ready. A failed read stops the pass at once and no write is issued. A failed write ends the operation with an error. Completion is signalled by a one-cycle done pulse, and a sticky error flag shows whether the operation failed.

Top module: `ee_csum_update`

## Requirements
- R1: After an accepted start, the block reads addresses 0 through 62 in strictly ascending order, exactly one read per address, with at most one request outstanding. A request and its address stay stable until `rd_ready_i` is high.
- R2: The sum of the words read is kept modulo 2^16. The block issues exactly one write, to address 63, with data 0xBABA minus that sum, truncated to 16 bits.
- R3: After a successful operation, the 63 read words plus the written word sum to 0xBABA modulo 2^16, including when the sum wraps.
- R4: A read that completes with `rd_err_i` high ends the operation at once. No further read and no write are issued, and `err_o` is set.
- R5: A write that completes with `wr_err_i` high ends the operation with `err_o` set.
- R6: `done_o` is high for exactly one cycle. It is due in the cycle after the handshake that ends the operation, whether that is the write or an aborting read.
- R7: `err_o` keeps its value until the next accepted start, which clears it.
- R8: A start received while `busy_o` is high is ignored. The read sequence and its result are unchanged.
- R9: After reset, `busy_o`, `done_o`, `err_o`, `rd_req_o` and `wr_req_o` are low.
- R10: The accumulator is cleared at each accepted start, so a repeated operation on the same image writes the same checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 6 | Read word address |
| rd_data_i | input | 16 | Read data, valid with rd_ready_i |
| rd_ready_i | input | 1 | Read completes |
| rd_err_i | input | 1 | Read failed, valid with rd_ready_i |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | 6 | Write word address |
| wr_data_o | output | 16 | Write data (checksum) |
| wr_ready_i | input | 1 | Write completes |
| wr_err_i | input | 1 | Write failed, valid with wr_ready_i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky error flag |

## Verification
A start sampled at a clock edge raises `busy_o` and `rd_req_o` after that edge. Each ready cycle either moves the address on in the next cycle or ends the pass. `done_o` is due one cycle after the ending handshake, and `err_o` changes in that same cycle. The bench drives all responses at the falling edge and timestamps each ending handshake. It then requires the done pulse to appear at exactly the next falling-edge sample and to be seen only once. The written data, the read order and the read and write counts are checked only after done, against a checksum the bench computes from its own image.

// File: rtl/ee_csum_pkg.sv
package ee_csum_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE
  } csum_state_e;
endpackage

// File: rtl/ee_csum_addr_ctr.sv
module ee_csum_addr_ctr #(
  parameter int ADDR_W = 6,
  parameter int LAST   = 62
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_o <= '0;
    else if (clr_i) addr_o <= '0;
    else if (inc_i) addr_o <= addr_o + 1'b1;
  end

  assign last_o = (addr_o == ADDR_W'(LAST));

  p_no_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && last_o) |-> 1'b0)
    else $error("address counter stepped past last read");
endmodule

// File: rtl/ee_csum_acc.sv
module ee_csum_acc #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sum_o
);
  // modulo 2^DATA_W wrap is intended
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_o <= '0;
    else if (clr_i) sum_o <= '0;
    else if (add_i) sum_o <= sum_o + data_i;
  end

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sum_o == '0))
    else $error("accumulator not cleared");
endmodule

// File: rtl/ee_csum_update.sv
module ee_csum_update
  import ee_csum_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          DATA_W    = 16,
  parameter int          WORDS     = 64,
  parameter logic [15:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_ready_i,
  input  logic              rd_err_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  input  logic              wr_err_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int CSUM_ADDR = WORDS - 1;
  localparam int LAST_RD   = WORDS - 2;

  csum_state_e       state_q;
  logic              accept, rd_fire, wr_fire, last_rd;
  logic [DATA_W-1:0] sum;
  logic              done_q, err_q;

  assign accept  = start_i && (state_q == ST_IDLE);
  assign rd_fire = (state_q == ST_READ) && rd_ready_i;
  assign wr_fire = (state_q == ST_WRITE) && wr_ready_i;

  ee_csum_addr_ctr #(.ADDR_W(ADDR_W), .LAST(LAST_RD)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .inc_i  (rd_fire && !rd_err_i && !last_rd),
    .addr_o (rd_addr_o),
    .last_o (last_rd)
  );

  ee_csum_acc #(.DATA_W(DATA_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .add_i  (rd_fire && !rd_err_i),
    .data_i (rd_data_i),
    .sum_o  (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_READ;
          err_q   <= 1'b0;
        end
        ST_READ: if (rd_ready_i) begin
          if (rd_err_i) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
            done_q  <= 1'b1;
          end else if (last_rd) begin
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: if (wr_ready_i) begin
          state_q <= ST_IDLE;
          err_q   <= wr_err_i;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (state_q == ST_READ);
  assign wr_req_o  = (state_q == ST_WRITE);
  assign wr_addr_o = ADDR_W'(CSUM_ADDR);
  assign wr_data_o = DATA_W'(SIGNATURE) - sum;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

  p_rd_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o)))
    else $error("read request dropped or address moved");
  p_one_port_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o))
    else $error("read and write outstanding together");
  p_wr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ready_i) |=> (wr_req_o && $stable(wr_data_o)))
    else $error("write request dropped or data moved");
  p_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_ready_i && rd_err_i) |=> (!wr_req_o && !rd_req_o && err_o))
    else $error("read error did not abort");
  p_wr_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_ready_i && wr_err_i) |=> err_o)
    else $error("write error not flagged");
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done wider than one cycle");
  p_err_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !busy_o && !start_i) |=> err_o)
    else $error("error flag lost while idle");
  p_busy_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && start_i && !rd_ready_i) |=> $stable(rd_addr_o))
    else $error("start while busy disturbed the pass");
endmodule

// File: tb/ee_csum_update_bench.sv
module ee_csum_update_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_req, wr_req, busy, done, err;
  logic [5:0]  rd_addr, wr_addr;
  logic [15:0] rd_data = '0, wr_data;
  logic        rd_ready = 1'b0, rd_err = 1'b0, wr_ready = 1'b0, wr_err = 1'b0;

  int checks = 0, errors = 0, cycle = 0;
  logic [15:0] mem [64];
  int lat = 0, err_addr = -1;
  bit wr_fail = 0;
  int rd_count, wr_count, order_bad, exp_addr, done_count, end_cyc, done_cyc;
  logic [15:0] wr_seen;
  logic [5:0]  wr_addr_seen;
  int          lat_cnt = 0;

  always #4 clk = ~clk;

  ee_csum_update u_ee_csum_update (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .rd_ready_i(rd_ready), .rd_err_i(rd_err),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_ready_i(wr_ready), .wr_err_i(wr_err),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // responder and monitor, all at the falling edge
  initial forever begin
    @(negedge clk);
    cycle++;
    if (done) begin done_count++; done_cyc = cycle; end
    rd_ready = 1'b0; rd_err = 1'b0; wr_ready = 1'b0; wr_err = 1'b0;
    if (rd_req) begin
      if (lat_cnt < lat) lat_cnt++;
      else begin
        lat_cnt = 0;
        rd_ready = 1'b1;
        rd_data = mem[rd_addr];
        rd_err = (int'(rd_addr) == err_addr);
        if (int'(rd_addr) != exp_addr) order_bad++;
        exp_addr++;
        rd_count++;
        if (rd_err) end_cyc = cycle;
      end
    end else if (wr_req) begin
      if (lat_cnt < lat) lat_cnt++;
      else begin
        lat_cnt = 0;
        wr_ready = 1'b1;
        wr_err = wr_fail;
        wr_seen = wr_data;
        wr_addr_seen = wr_addr;
        wr_count++;
        end_cyc = cycle;
      end
    end
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [15:0] image_sum();
    logic [15:0] s = '0;
    for (int i = 0; i < 63; i++) s = s + mem[i];
    return s;
  endfunction

  task automatic run_op(input bit extra_start);
    rd_count = 0; wr_count = 0; order_bad = 0; exp_addr = 0;
    done_count = 0; end_cyc = -1; done_cyc = -2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (done_count == 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!busy && !done && !err && !rd_req && !wr_req, "R9 reset state",
          {busy, done, err, rd_req, wr_req}, 0);
  endtask

  task automatic t_normal(input string tag, input bit extra);
    logic [15:0] exp = 16'hBABA - image_sum();
    run_op(extra);
    check(order_bad == 0 && rd_count == 63, {"R1 read order/count ", tag}, rd_count, 63);
    check(wr_count == 1 && wr_addr_seen == 6'd63, {"R2 one write to 63 ", tag},
          wr_addr_seen, 63);
    check(wr_seen == exp, {"R2 checksum ", tag}, wr_seen, exp);
    check(16'(image_sum() + wr_seen) == 16'hBABA, {"R3 image sums to signature ", tag},
          16'(image_sum() + wr_seen), 16'hBABA);
    check(done_count == 1 && done_cyc == end_cyc + 1, {"R6 done timing ", tag},
          done_cyc - end_cyc, 1);
    check(!err, {"R5 no error ", tag}, err, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0123 + 16'h0011);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();

    t_normal("ramp", 1'b0);
    lat = 2;
    t_normal("ramp lat2 R10 repeat", 1'b0);

    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
    lat = 0;
    t_normal("wrap all ones", 1'b0);

    // R8 start during busy
    for (int i = 0; i < 64; i++) mem[i] = 16'(16'hA5A5 ^ (i << 7));
    lat = 1;
    t_normal("R8 start while busy", 1'b1);

    // R4 read error aborts
    err_addr = 10; lat = 0;
    run_op(1'b0);
    check(wr_count == 0, "R4 no write after read error", wr_count, 0);
    check(rd_count == 11, "R4 reads stop at error", rd_count, 11);
    check(err, "R4 error flag", err, 1);
    check(done_count == 1 && done_cyc == end_cyc + 1, "R6 done after abort",
          done_cyc - end_cyc, 1);
    repeat (10) @(negedge clk);
    check(err && !busy, "R7 error held while idle", err, 1);
    err_addr = -1;

    // R7 cleared by next start
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!err && busy, "R7 error cleared on start", err, 0);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);

    // R5 write error
    wr_fail = 1'b1;
    run_op(1'b0);
    check(err && wr_count == 1, "R5 write error flagged", err, 1);
    check(done_count == 1 && done_cyc == end_cyc + 1, "R6 done after write error",
          done_cyc - end_cyc, 1);
    wr_fail = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule